// File: doc/BRIEF.md
# Garage Door Motion Controller

This block is the sequencing brain of a simple garage door. A single remote button either starts the door or stops it. When the door is at rest, a press sends it the opposite way from its last travel. When the door is moving, a press halts it. An obstruction sensor stops the door from starting downward and sends a descending door back up at once. Two end-of-travel switches end motion at the top and at the bottom. The block drives two motor commands, one to raise the door and one to lower it.

The controller runs from the system clock but advances only on a one-cycle enable pulse (`tick`), nominally every millisecond. Every input is captured into a register on each tick. The state then acts on the captured copy at the following tick, so any input change reaches the motor outputs two ticks after it is applied. The inputs are assumed to be already debounced.

The remote button is treated by its rising edge across ticks, so holding it down counts as one press. When a press stops a moving door, the machine waits in a dedicated state until the button is released. Only then does it settle into the resting state that matches the direction it was travelling. The machine has seven states, and the unused encoding falls back to the fully-closed state.

Top module: `garage_door_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the door in the closed-and-resting state with both motor outputs low. The first press after reset raises the door.
- R2: A press while the door is at rest starts motion opposite to the last travel. From fully closed, or stopped after descending, `motor_up` rises. From fully open, or stopped after ascending, `motor_down` rises.
- R3: A press while the door is moving drops both motor outputs. They stay low while the button is held. After release the door rests, and the next press reverses its direction.
- R4: While the obstruction input is high, a press in the fully-open state or in the stopped-after-ascending state is ignored, and `motor_down` stays low.
- R5: An obstruction seen while the door descends switches the outputs to `motor_up`. This takes priority over the bottom limit switch and over a press in the same tick.
- R6: The top limit switch (`at_top`) ends upward motion and the bottom limit switch (`at_bottom`) ends downward motion, leaving both motor outputs low. Each switch is ignored outside the motion it ends. While the door rises, the top limit wins over a press in the same tick.
- R7: A button held high across many ticks counts as one press only. A new press needs the sampled button to go low and then high again.
- R8: State changes happen only on a clock edge where `tick` is high. An input applied before tick k is acted on at tick k+1, so the outputs stay constant between ticks.
- R9: `motor_up` and `motor_down` are never high together, and both are low in every state except rising and descending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle advance enable, nominally 1 ms apart |
| click | input | 1 | Debounced remote button, high while pressed |
| obstruct | input | 1 | Obstruction sensor, high when the beam is blocked |
| at_top | input | 1 | Limit switch, high when the door is fully open |
| at_bottom | input | 1 | Limit switch, high when the door is fully closed |
| motor_up | output | 1 | Command to drive the door upward |
| motor_down | output | 1 | Command to drive the door downward |

## Verification
The bench walks the door through every state and compares the motor outputs two ticks after each input change. The corner cases it targets are listed below, each with the fault it would expose.

- **Direction after a mid-travel stop.** A design without direction memory would restart the same way it was going.
- **Held button.** A design that reads the button level instead of its edge would stop a door and then restart it on the same press.
- **Obstruction and bottom limit in the same tick.** A design with the wrong priority would park the door closed instead of raising it.
- **Obstructed press from the open and stopped-after-ascending states.** A design that skips the veto would start descending.
- **Input changes without a tick.** Outputs that move here would reveal a missing enable or a missing input register.

// File: rtl/gdc_pkg.sv
// Package: shared state, direction and sampled-input types for the
// garage door controller. Assumes a 3-bit state encoding with one unused code.
package gdc_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_SHUT         = 3'd0,  // fully closed, at rest
        ST_RAISE        = 3'd1,  // motor driving up
        ST_FULL_UP      = 3'd2,  // fully open, at rest
        ST_LOWER        = 3'd3,  // motor driving down
        ST_HALT_UP      = 3'd4,  // stopped part way after rising
        ST_HALT_DOWN    = 3'd5,  // stopped part way after descending
        ST_WAIT_RELEASE = 3'd6   // motion stopped, waiting for button release
    } gdc_state_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } gdc_dir_e;

    typedef struct packed {
        logic click;     // button level as captured at the last tick
        logic press;     // rising edge of the button across ticks
        logic obstruct;  // obstruction level as captured
        logic top;       // top limit as captured
        logic bottom;    // bottom limit as captured
    } gdc_sample_t;

endpackage

// File: rtl/gdc_input_stage.sv
// Module: gdc_input_stage
// Captures the four controller inputs once per tick and derives a single
// press pulse from the button's rising edge between consecutive ticks.
// Assumes the inputs are already debounced and that tick is a one-cycle pulse.
module gdc_input_stage
    import gdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        click_i,
    input  logic        obstruct_i,
    input  logic        top_i,
    input  logic        bottom_i,
    output gdc_sample_t smp_o
);

    logic click_q;
    logic click_prev_q;
    logic obstruct_q;
    logic top_q;
    logic bottom_q;

    // Input capture register: loads on each tick, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            click_q      <= 1'b0;
            click_prev_q <= 1'b0;
            obstruct_q   <= 1'b0;
            top_q        <= 1'b0;
            bottom_q     <= 1'b0;
        end else if (tick) begin
            click_q      <= click_i;
            click_prev_q <= click_q;
            obstruct_q   <= obstruct_i;
            top_q        <= top_i;
            bottom_q     <= bottom_i;
        end
    end

    // Pack the captured levels and the press edge for the decoder.
    always_comb begin
        smp_o.click    = click_q;
        smp_o.press    = click_q & ~click_prev_q;
        smp_o.obstruct = obstruct_q;
        smp_o.top      = top_q;
        smp_o.bottom   = bottom_q;
    end

endmodule

// File: rtl/gdc_next_state.sv
// Module: gdc_next_state
// Purely combinational next-state and direction-memory decoder.
// Priorities: obstruction over the bottom limit over a press while descending;
// the top limit over a press while rising. Unused codes return to ST_SHUT.
module gdc_next_state
    import gdc_pkg::*;
(
    input  gdc_state_e  state_i,
    input  gdc_dir_e    dir_i,
    input  gdc_sample_t smp_i,
    output gdc_state_e  state_o,
    output gdc_dir_e    dir_o
);

    // Transition table of the seven states.
    always_comb begin
        state_o = state_i;
        unique case (state_i)
            ST_SHUT: begin
                if (smp_i.press) state_o = ST_RAISE;
            end
            ST_RAISE: begin
                if (smp_i.top)        state_o = ST_FULL_UP;
                else if (smp_i.press) state_o = ST_WAIT_RELEASE;
            end
            ST_FULL_UP: begin
                if (smp_i.press && !smp_i.obstruct) state_o = ST_LOWER;
            end
            ST_LOWER: begin
                if (smp_i.obstruct)     state_o = ST_RAISE;
                else if (smp_i.bottom)  state_o = ST_SHUT;
                else if (smp_i.press)   state_o = ST_WAIT_RELEASE;
            end
            ST_HALT_UP: begin
                if (smp_i.press && !smp_i.obstruct) state_o = ST_LOWER;
            end
            ST_HALT_DOWN: begin
                if (smp_i.press) state_o = ST_RAISE;
            end
            ST_WAIT_RELEASE: begin
                if (!smp_i.click)
                    state_o = (dir_i == DIR_UP) ? ST_HALT_UP : ST_HALT_DOWN;
            end
            default: state_o = ST_SHUT;
        endcase
    end

    // Direction memory: follows every entry into a moving state.
    always_comb begin
        dir_o = dir_i;
        if (state_o == ST_RAISE)      dir_o = DIR_UP;
        else if (state_o == ST_LOWER) dir_o = DIR_DOWN;
    end

endmodule

// File: rtl/gdc_motor_decode.sv
// Module: gdc_motor_decode
// Output decoder: maps the registered state to the two motor commands.
// Assumes the state comes straight from a flop, so the outputs are glitch-free.
module gdc_motor_decode
    import gdc_pkg::*;
(
    input  gdc_state_e state_i,
    output logic       up_o,
    output logic       down_o
);

    // Only the two moving states drive the motor.
    always_comb begin
        up_o   = 1'b0;
        down_o = 1'b0;
        case (state_i)
            ST_RAISE: up_o   = 1'b1;
            ST_LOWER: down_o = 1'b1;
            default: begin
                up_o   = 1'b0;
                down_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/garage_door_ctrl.sv
// Module: garage_door_ctrl
// Top level of the garage door controller: input capture, state and direction
// registers advanced on tick, and the motor output decoder.
// Assumes debounced inputs and a one-cycle tick pulse; the reset is synchronous.
module garage_door_ctrl
    import gdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic click,
    input  logic obstruct,
    input  logic at_top,
    input  logic at_bottom,
    output logic motor_up,
    output logic motor_down
);

    gdc_sample_t smp;
    gdc_state_e  state_q;
    gdc_state_e  state_d;
    gdc_dir_e    dir_q;
    gdc_dir_e    dir_d;

    gdc_input_stage u_in (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .click_i    (click),
        .obstruct_i (obstruct),
        .top_i      (at_top),
        .bottom_i   (at_bottom),
        .smp_o      (smp)
    );

    gdc_next_state u_ns (
        .state_i (state_q),
        .dir_i   (dir_q),
        .smp_i   (smp),
        .state_o (state_d),
        .dir_o   (dir_d)
    );

    // State and direction registers: advance on tick only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SHUT;
            dir_q   <= DIR_DOWN;
        end else if (tick) begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    gdc_motor_decode u_dec (
        .state_i (state_q),
        .up_o    (motor_up),
        .down_o  (motor_down)
    );

endmodule

// File: rtl/gdc_checker.sv
// Module: gdc_checker
// Property checker for garage_door_ctrl, attached with bind below.
// Observes the ports plus the state register and the captured obstruction bit.
module gdc_checker
    import gdc_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                motor_up,
    input logic                motor_down,
    input logic [STATE_W-1:0]  state_i,
    input logic                obs_i
);

    // R9: the motor is never told to go both ways at once.
    assert_motor_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_up && motor_down));

    // R9: the motor is idle outside the two moving states.
    assert_idle_motor_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_RAISE && state_i != ST_LOWER) |-> (!motor_up && !motor_down));

    // R1: the first cycle after reset shows the motor off.
    assert_reset_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!motor_up && !motor_down && state_i == ST_SHUT));

    // R8: without a tick on the previous edge the outputs hold.
    assert_hold_without_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick)) |-> ($stable(motor_up) && $stable(motor_down)));

    // R5: obstruction while descending reverses to rising.
    assert_obstruct_reverses_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_i == ST_LOWER && obs_i) |=> (state_i == ST_RAISE));

    // R4: obstruction keeps the machine out of the descending state.
    assert_obstruct_blocks_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && obs_i && state_i != ST_LOWER) |=> (state_i != ST_LOWER));

endmodule

bind garage_door_ctrl gdc_checker u_gdc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .motor_up   (motor_up),
    .motor_down (motor_down),
    .state_i    (state_q),
    .obs_i      (smp.obstruct)
);

// File: tb/garage_door_ctrl_bench.sv
// Bench for garage_door_ctrl: a vector table walked by one loop, then directed
// tests for tick-less stability, reset during motion and obstruction priority.
module garage_door_ctrl_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 24;
    localparam int  WATCHDOG   = 200000;

    // Each entry: {click, obstruct, at_top, at_bottom, exp_up, exp_down}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b100010, // R2 closed, press -> up
        6'b000010, // R2 release, keeps rising
        6'b001000, // R6 top limit -> rest open
        6'b110000, // R4 obstructed press ignored
        6'b010000, // R4 still resting
        6'b100001, // R2 open, press -> down
        6'b000001, // R2 keeps descending
        6'b010010, // R5 obstruction reverses
        6'b000010, // R5 keeps rising
        6'b100000, // R3 press while moving -> stop
        6'b100000, // R7 held press, still stopped
        6'b000000, // R3 release -> rest after rising
        6'b110000, // R4 obstructed press from halt ignored
        6'b000000, // R4 still halted
        6'b100001, // R2 halt after rising -> down
        6'b000001, // R2 keeps descending
        6'b100000, // R3 stop while descending
        6'b000000, // R3 release -> rest after descending
        6'b100010, // R2 halt after descending -> up
        6'b000010, // R2 keeps rising
        6'b001000, // R6 top limit
        6'b100001, // R2 press -> down
        6'b000100, // R6 bottom limit -> closed
        6'b100010  // R2 closed -> up
    };
    localparam int VREQ [NVEC] = '{2,2,6,4,4,2,2,5,5,3,7,3,4,4,2,2,3,3,2,2,6,2,6,2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic click = 1'b0;
    logic obstruct = 1'b0;
    logic at_top = 1'b0;
    logic at_bottom = 1'b0;
    logic motor_up;
    logic motor_down;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    garage_door_ctrl u_garage_door_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .click      (click),
        .obstruct   (obstruct),
        .at_top     (at_top),
        .at_bottom  (at_bottom),
        .motor_up   (motor_up),
        .motor_down (motor_down)
    );

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_up, input logic exp_dn);
        checks++;
        if (motor_up !== exp_up || motor_down !== exp_dn) begin
            errors++;
            $display("FAIL %s: up/down actual=%b%b expected=%b%b at %0t",
                     req, motor_up, motor_down, exp_up, exp_dn, $time);
        end
    endtask

    task automatic apply(input logic c, input logic o, input logic t, input logic b);
        @(negedge clk);
        click = c; obstruct = o; at_top = t; at_bottom = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            pulse_tick();
            pulse_tick();
            check($sformatf("R%0d vec%0d", VREQ[i], i), VEC[i][1], VEC[i][0]);
        end

        // R8: inputs change without a tick, outputs must hold (door rising).
        apply(1'b0, 1'b0, 1'b1, 1'b0);
        repeat (10) @(negedge clk);
        check("R8 no tick", 1'b1, 1'b0);
        pulse_tick();
        check("R8 one tick latency", 1'b1, 1'b0);
        pulse_tick();
        check("R6 top after two ticks", 1'b0, 1'b0);

        // R1: reset while descending, then first press raises.
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        pulse_tick();
        pulse_tick();
        check("R2 open -> down", 1'b0, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset in motion", 1'b0, 1'b0);
        rst_n = 1'b1;
        pulse_tick();
        pulse_tick();
        check("R1 first press raises", 1'b1, 1'b0);

        // R5: obstruction and bottom limit together while descending.
        apply(1'b0, 1'b0, 1'b1, 1'b0);
        pulse_tick();
        pulse_tick();
        check("R6 top limit", 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        pulse_tick();
        pulse_tick();
        check("R2 down again", 1'b0, 1'b1);
        apply(1'b0, 1'b1, 1'b0, 1'b1);
        pulse_tick();
        pulse_tick();
        check("R5 obstruction beats bottom limit", 1'b1, 1'b0);
        apply(1'b0, 1'b0, 1'b0, 1'b1);
        pulse_tick();
        pulse_tick();
        check("R6 bottom limit ignored while rising", 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule